// File: doc/BRIEF.md
# Sticky-Reset Error Register Bank

This block is a small bank of 64-bit control and error registers reached through a single-cycle register port. A write takes effect at the clock edge. Read data is combinational from the address in the same cycle. The bank holds the following registers:

- a main control register;
- a reset-control register;
- a self-clearing error-inject register;
- a primary error-status register;
- a secondary error-status register;
- two error-log registers;
- two status-mask registers.

The bank has two reset domains. A hard power-on reset is asserted asynchronously and released synchronously. It clears every bit and loads the fixed reset values. A soft core reset is started by software through a request bit in the reset-control register. It gives each register (current AND sticky) OR (reset value AND NOT sticky), using a sticky mask of that register's own. Error history therefore survives the soft reset, while control state returns to its defaults.

Bit positions below are LSB-0, with bit 63 the most significant. Register word addresses are: control 0, reset-control 1, inject 2, primary status 3, secondary status 4, log A 5, log B 6, primary mask 7, secondary mask 8. Addresses 9 to 15 are unmapped.

Top module: `sticky_bank`

## Requirements
- R1: While and after hard reset (rstN low), control reads 0xC009_0000_0000_0000, reset-control reads 0xE000_0000_0000_0000, and every other address reads zero. This includes all sticky bits.
- R2: A write with wrEn high stores wdata at the addressed storage register (addresses 0, 1, 3 to 8) at the clock edge. rdata shows the addressed register in the same cycle. Addresses 9 to 15 read zero, and writes to them change nothing.
- R3: A write to reset-control with bit 61 set stores the written value at that edge. It applies the soft reset at the following edge. No register other than reset-control changes at the first edge.
- R4: On a soft reset the primary status register keeps bits 63:54 and 51:0 and clears bits 53:52.
- R5: On a soft reset the secondary status, both log and both mask registers keep all 64 bits.
- R6: On a soft reset the control register reloads 0xC009_0000_0000_0000.
- R7: On a soft reset reset-control keeps bits 60 and 55. All its other bits take 0xC000_0000_0000_0000, so the request bit 61 reads zero afterwards.
- R8: A write to the inject address (2) copies wdata into the primary status register at that edge. The inject address always reads zero.
- R9: A register write presented in the cycle where the soft reset is applied is ignored. The soft reset wins.
- R10: Injecting all ones and then soft-resetting leaves the primary status at 0xFFCF_FFFF_FFFF_FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Hard reset, active low, asynchronous assert |
| wrEn | input | 1 | Write enable |
| addr | input | ADDR_W (4) | Register word address |
| wdata | input | DATA_W (64) | Write data |
| rdata | output | DATA_W (64) | Combinational read data |

## Verification
The bench builds the block with its defaults: DATA_W of 64 and ADDR_W of 4. A 4-bit address spans the nine mapped registers and seven unmapped addresses, so reads and ignored writes on unmapped addresses can be exercised. The full 64-bit width puts the sticky boundary at bits 53:52 of the status register within reach. It also covers the scattered sticky bits 60 and 55 of reset-control and the self-clearing request bit at 61. Both soft-reset passes are compared against a merge computed in the bench, and one pass places a competing write in the cycle the reset lands.

// File: rtl/sticky_bank_pkg.sv
package sticky_bank_pkg;

  localparam int REG_W     = 64;
  localparam int NUM_REGS  = 9;
  localparam int SOFT_REQ_BIT = 61;

  typedef enum logic [3:0] {
    REG_CTRL      = 4'd0,
    REG_RSTCTL    = 4'd1,
    REG_INJECT    = 4'd2,
    REG_ERRSTAT   = 4'd3,
    REG_ERRSTAT2  = 4'd4,
    REG_ERRLOG0   = 4'd5,
    REG_ERRLOG1   = 4'd6,
    REG_STATMASK  = 4'd7,
    REG_STAT2MASK = 4'd8
  } regId_e;

  localparam logic [REG_W-1:0] CTRL_RST_VAL   = 64'hC009_0000_0000_0000;
  localparam logic [REG_W-1:0] RSTCTL_HARD    = 64'hE000_0000_0000_0000;
  localparam logic [REG_W-1:0] RSTCTL_SOFT    = RSTCTL_HARD & ~(64'd1 << SOFT_REQ_BIT);
  localparam logic [REG_W-1:0] RSTCTL_STICKY  = (64'd1 << 60) | (64'd1 << 55);
  localparam logic [REG_W-1:0] ERRSTAT_STICKY = ~((64'd1 << 53) | (64'd1 << 52));

  typedef struct packed {
    logic                softRst;
    logic                injStb;
    logic [NUM_REGS-1:0] wrStb;
  } bankStb_t;

  function automatic logic [REG_W-1:0] stickyMaskOf(input int idx);
    case (idx)
      int'(REG_RSTCTL):    return RSTCTL_STICKY;
      int'(REG_ERRSTAT):   return ERRSTAT_STICKY;
      int'(REG_ERRSTAT2),
      int'(REG_ERRLOG0),
      int'(REG_ERRLOG1),
      int'(REG_STATMASK),
      int'(REG_STAT2MASK): return '1;
      default:             return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] hardValOf(input int idx);
    case (idx)
      int'(REG_CTRL):   return CTRL_RST_VAL;
      int'(REG_RSTCTL): return RSTCTL_HARD;
      default:          return '0;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] softValOf(input int idx);
    case (idx)
      int'(REG_CTRL):   return CTRL_RST_VAL;
      int'(REG_RSTCTL): return RSTCTL_SOFT;
      default:          return '0;
    endcase
  endfunction

endpackage

// File: rtl/sticky_bank_ctrl.sv
module sticky_bank_ctrl
  import sticky_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              reqBit,
  output bankStb_t          stb
);

  logic softPend;
  logic [NUM_REGS-1:0] decHit;

  // one-hot address decode
  always_comb begin
    decHit = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(addr) == i) decHit[i] = 1'b1;
    end
  end

  // request flop: a request write arms it, it drops after one cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      softPend <= 1'b0;
    end else if (softPend) begin
      softPend <= 1'b0;
    end else begin
      softPend <= wrEn && decHit[REG_RSTCTL] && reqBit;
    end
  end

  always_comb begin
    stb.softRst = softPend;
    stb.injStb  = wrEn && !softPend && decHit[REG_INJECT];
    stb.wrStb   = (wrEn && !softPend) ? decHit : '0;
    stb.wrStb[REG_INJECT] = 1'b0;
  end

endmodule

// File: rtl/sticky_bank_dp.sv
module sticky_bank_dp
  import sticky_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStb_t          stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] regQ [NUM_REGS]
);

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] STK  = DATA_W'(stickyMaskOf(i));
    localparam logic [DATA_W-1:0] HARD = DATA_W'(hardValOf(i));
    localparam logic [DATA_W-1:0] SOFT = DATA_W'(softValOf(i));
    localparam bit IS_STATUS = (i == int'(REG_ERRSTAT));

    if (i == int'(REG_INJECT)) begin : g_inj
      // inject has no storage; its write is steered to the status register
      assign regQ[i] = '0;
    end else begin : g_store
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ[i] <= HARD;
        end else if (stb.softRst) begin
          regQ[i] <= (regQ[i] & STK) | (SOFT & ~STK);
        end else if (stb.wrStb[i]) begin
          regQ[i] <= wdata;
        end else if (IS_STATUS && stb.injStb) begin
          regQ[i] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(addr) < NUM_REGS) rdata = regQ[addr];
  end

endmodule

// File: rtl/sticky_bank.sv
module sticky_bank
  import sticky_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  bankStb_t stb;
  logic [DATA_W-1:0] regQ [NUM_REGS];

  sticky_bank_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .reqBit (wdata[SOFT_REQ_BIT]),
    .stb    (stb)
  );

  sticky_bank_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .stb   (stb),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata),
    .regQ  (regQ)
  );

endmodule

// File: rtl/sticky_bank_chk.sv
module sticky_bank_chk
  import sticky_bank_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = REG_W
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input bankStb_t          stb,
  input logic [DATA_W-1:0] regs [NUM_REGS]
);

  a_r4_status_merge: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> regs[REG_ERRSTAT] == ($past(regs[REG_ERRSTAT]) & 64'hFFCF_FFFF_FFFF_FFFF));

  a_r5_log_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> regs[REG_ERRLOG0] == $past(regs[REG_ERRLOG0]));

  a_r5_mask_kept: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> regs[REG_STAT2MASK] == $past(regs[REG_STAT2MASK]));

  a_r6_ctrl_reload: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> regs[REG_CTRL] == 64'hC009_0000_0000_0000);

  a_r7_req_cleared: assert property (@(posedge clk) disable iff (!rstN)
    stb.softRst |=> (!regs[REG_RSTCTL][61] && !stb.softRst));

  a_r3_request_arms: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(REG_RSTCTL) && wdata[61] && !stb.softRst) |=> stb.softRst);

  a_r8_inject_copy: assert property (@(posedge clk) disable iff (!rstN)
    stb.injStb |=> regs[REG_ERRSTAT] == $past(wdata));

  a_r8_inject_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (addr == ADDR_W'(REG_INJECT)) |-> rdata == '0);

  a_r9_soft_wins: assert property (@(posedge clk) disable iff (!rstN)
    (stb.softRst && wrEn && addr == ADDR_W'(REG_CTRL)) |=> regs[REG_CTRL] == 64'hC009_0000_0000_0000);

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (int'(addr) >= NUM_REGS) |-> rdata == '0);

endmodule

bind sticky_bank sticky_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
  .clk   (clk),
  .rstN  (rstN),
  .wrEn  (wrEn),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .stb   (stb),
  .regs  (regQ)
);

// File: tb/sticky_bank_tb_top.sv
`timescale 1ns/1ps
module sticky_bank_tb_top;

  localparam logic [63:0] CTRL_RV   = 64'hC009_0000_0000_0000;
  localparam logic [63:0] RC_HARD   = 64'hE000_0000_0000_0000;
  localparam logic [63:0] RC_SOFT   = 64'hC000_0000_0000_0000;
  localparam logic [63:0] RC_STK    = 64'h1080_0000_0000_0000;
  localparam logic [63:0] ST_STK    = 64'hFFCF_FFFF_FFFF_FFFF;
  localparam logic [63:0] REQ       = 64'h2000_0000_0000_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sticky_bank dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wrEn = 1'b0;
  endtask

  task automatic rdNow(input logic [3:0] a, output logic [63:0] v);
    addr = a;
    #2 v = rdata;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] v);
    @(negedge clk);
    rdNow(a, v);
  endtask

  function automatic logic [63:0] merge(input logic [63:0] cur, input logic [63:0] rv,
                                        input logic [63:0] stk);
    return (cur & stk) | (rv & ~stk);
  endfunction

  task automatic t_reset_state();
    logic [63:0] v;
    rd(4'd0, v); check("R1 ctrl", v, CTRL_RV);
    rd(4'd1, v); check("R1 rstctl", v, RC_HARD);
    for (int a = 2; a < 9; a++) begin
      rd(4'(a), v); check("R1 other", v, 64'd0);
    end
  endtask

  task automatic t_read_write();
    logic [63:0] v;
    wr(4'd0, 64'h0123_4567_89AB_CDEF); rd(4'd0, v); check("R2 ctrl rw", v, 64'h0123_4567_89AB_CDEF);
    wr(4'd4, 64'hA5A5_0000_FFFF_5A5A); rd(4'd4, v); check("R2 stat2 rw", v, 64'hA5A5_0000_FFFF_5A5A);
    wr(4'd5, 64'h1111_2222_3333_4444); rd(4'd5, v); check("R2 logA rw", v, 64'h1111_2222_3333_4444);
    wr(4'd6, 64'h8000_0000_0000_0001); rd(4'd6, v); check("R2 logB rw", v, 64'h8000_0000_0000_0001);
    wr(4'd7, 64'hFFFF_0000_FFFF_0000); rd(4'd7, v); check("R2 mask rw", v, 64'hFFFF_0000_FFFF_0000);
    wr(4'd8, 64'h0F0F_0F0F_0F0F_0F0F); rd(4'd8, v); check("R2 mask2 rw", v, 64'h0F0F_0F0F_0F0F_0F0F);
    wr(4'd12, 64'hDEAD_BEEF_DEAD_BEEF); rd(4'd12, v); check("R2 unmapped", v, 64'd0);
    rd(4'd0, v); check("R2 unmapped write leaves ctrl", v, 64'h0123_4567_89AB_CDEF);
    rd(4'd15, v); check("R2 unmapped top", v, 64'd0);
  endtask

  task automatic t_inject();
    logic [63:0] v;
    wr(4'd2, 64'h0030_1234_5678_9ABC);
    rd(4'd3, v); check("R8 inject copy", v, 64'h0030_1234_5678_9ABC);
    rd(4'd2, v); check("R8 inject reads zero", v, 64'd0);
  endtask

  task automatic t_soft_all_ones();
    logic [63:0] v;
    wr(4'd2, '1);
    wr(4'd1, REQ | (64'd1 << 55));
    // first edge done: only reset-control changed
    rdNow(4'd1, v); check("R3 request stored", v, REQ | (64'd1 << 55));
    rdNow(4'd3, v); check("R3 status untouched before reset", v, '1);
    // write competing with the soft reset edge
    wr(4'd0, 64'h5555_5555_5555_5555);
    rd(4'd3, v); check("R10 status after soft", v, 64'hFFCF_FFFF_FFFF_FFFF);
    check("R4 status merge", v, merge('1, 64'd0, ST_STK));
    rd(4'd0, v); check("R9 write ignored, R6 ctrl reload", v, CTRL_RV);
    rd(4'd1, v); check("R7 rstctl merge", v, merge(REQ | (64'd1 << 55), RC_SOFT, RC_STK));
    rd(4'd4, v); check("R5 stat2 kept", v, 64'hA5A5_0000_FFFF_5A5A);
    rd(4'd5, v); check("R5 logA kept", v, 64'h1111_2222_3333_4444);
    rd(4'd6, v); check("R5 logB kept", v, 64'h8000_0000_0000_0001);
    rd(4'd7, v); check("R5 mask kept", v, 64'hFFFF_0000_FFFF_0000);
    rd(4'd8, v); check("R5 mask2 kept", v, 64'h0F0F_0F0F_0F0F_0F0F);
  endtask

  task automatic t_soft_pattern();
    logic [63:0] v;
    wr(4'd2, 64'h0030_0000_0000_00A5);
    wr(4'd0, 64'h0000_0000_0000_0077);
    wr(4'd1, REQ | (64'd1 << 60));
    repeat (2) @(posedge clk);
    rd(4'd3, v); check("R4 status bits 53:52 cleared", v, 64'h0000_0000_0000_00A5);
    rd(4'd1, v); check("R7 bit60 kept, request cleared", v, 64'hD000_0000_0000_0000);
    rd(4'd0, v); check("R6 ctrl reload", v, CTRL_RV);
    // a write without the request bit does not reset
    wr(4'd0, 64'h0000_0000_0000_0042);
    wr(4'd1, 64'h0000_0000_0000_0000);
    repeat (2) @(posedge clk);
    rd(4'd0, v); check("R3 no request no reset", v, 64'h0000_0000_0000_0042);
  endtask

  task automatic t_hard_reset();
    logic [63:0] v;
    @(negedge clk); rstN = 1'b0;
    rdNow(4'd5, v); check("R1 hard clears sticky log", v, 64'd0);
    rdNow(4'd3, v); check("R1 hard clears status", v, 64'd0);
    rdNow(4'd1, v); check("R1 hard rstctl", v, RC_HARD);
    @(negedge clk); rstN = 1'b1;
    rd(4'd0, v); check("R1 ctrl after hard", v, CTRL_RV);
    rd(4'd8, v); check("R1 mask2 after hard", v, 64'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    t_reset_state();
    t_read_write();
    t_inject();
    t_soft_all_ones();
    t_soft_pattern();
    t_hard_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule